// File: doc/BRIEF.md
# Time-Multiplexed Shared Cache Port Sequencer

This block lets four slow cores share one cache port whose clock runs four times faster than the core clock. A two-bit slot counter steps on every cache clock, so each core cycle holds four cache slots. In every slot the sequencer chooses one core's request lines, forwards its address, write data and write flag to the single cache port, and tags the access so that the fixed-latency response goes back to the core that issued it. Because all cores of the cluster reach the same cache instance, they need no coherence traffic among themselves.

A mode input picks how slots and cache ways are spread over the cores. In the all-core mode every core owns one slot and one way. In the pair mode two cores run at twice the speed, each owning two alternating slots and two ways. In the two solo modes (4x and 8x speed-up, which look the same at this port because the cache clock scales along) one core owns every slot and every way. Requests from cores that a mode disables are ignored. A new mode stops fresh issues at once and is adopted at the next slot-0 boundary, once every outstanding response has returned.

Top module: `cache_slot_seq`

## Requirements
- R1: After reset, `slot_o` increases by one (modulo 4) on every cache clock edge at which `phase_i` is low.
- R2: A clock edge at which `phase_i` is high sets `slot_o` to 0, whatever its previous value.
- R3: In mode 0 (all cores), slot s serves only core s, and an issued access carries way mask `1 << s`.
- R4: In mode 1 (pair), only cores 0 and 1 are active: even slots serve core 0 with way mask 4'b0101, odd slots serve core 1 with way mask 4'b1010.
- R5: In modes 2 and 3 (solo 4x and 8x), core 0 owns all four slots and every issued access carries way mask 4'b1111.
- R6: A request from a core that the mode disables, or from a core that does not own the current slot, gives no grant and no cache request; the way mask reads 0 in any slot with no issue.
- R7: On an issue, `cache_req_o` is high, `core_gnt_o` is one-hot on the serving core, and `cache_addr_o`, `cache_wdata_o`, `cache_we_o` and `cache_core_o` carry that core's request fields and index in the same cycle.
- R8: The cache answers exactly RESP_LAT clock edges after an issue; `core_rvalid_o` then marks only the issuing core and `core_rdata_o` carries the returned data.
- R9: While `mode_i` differs from `mode_o` no access is issued; `mode_o` takes the new value only at an edge where the slot returns to 0 and no response is outstanding.
- R10: During and right after reset, `slot_o` is 0, `mode_o` is 0, and no request, grant or response valid is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cache clock (four times the core clock) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_i | input | 1 | Core-clock phase strobe; high in the last slot of a core cycle |
| mode_i | input | 2 | Requested mode: 0 all, 1 pair, 2 solo 4x, 3 solo 8x |
| core_req_i | input | 4 | Request valid per core |
| core_we_i | input | 4 | Write flag per core |
| core_addr_i | input | 4*AW | Packed per-core addresses, core k at bits k*AW |
| core_wdata_i | input | 4*DW | Packed per-core write data, core k at bits k*DW |
| core_gnt_o | output | 4 | One-hot grant to the core served this slot |
| core_rvalid_o | output | 4 | Response valid per core |
| core_rdata_o | output | DW | Response data shared by all cores |
| cache_req_o | output | 1 | Access valid to the cache |
| cache_we_o | output | 1 | Write flag to the cache |
| cache_addr_o | output | AW | Address to the cache |
| cache_wdata_o | output | DW | Write data to the cache |
| cache_way_en_o | output | 4 | Ways the access may allocate into |
| cache_core_o | output | 2 | Index of the serving core |
| cache_rvalid_i | input | 1 | Response valid from the cache |
| cache_rdata_i | input | DW | Response data from the cache |
| slot_o | output | 2 | Current slot |
| mode_o | output | 2 | Mode in force |

## Verification
The assertions take for granted that `phase_i` comes at most once per four cycles in normal running and that the cache raises `cache_rvalid_i` only exactly RESP_LAT edges after an issue, never on its own. The bench drives the strobe from its own slot count, breaking the cadence only in the realignment test, and raises the cache response by hand only in the cycle its fixed latency predicts. Mode is changed only through a task that holds requests high and waits for the switch, so each pending phase is observed under traffic.

// File: rtl/cache_slot_seq_pkg.sv
package cache_slot_seq_pkg;
  localparam int unsigned NCORE = 4;
  localparam int unsigned NWAY  = 4;
  localparam int unsigned CW    = $clog2(NCORE);

  typedef enum logic [1:0] {
    MODE_ALL       = 2'd0,
    MODE_PAIR      = 2'd1,
    MODE_SOLO      = 2'd2,
    MODE_SOLO_FAST = 2'd3
  } seq_mode_e;

  typedef struct packed {
    logic          vld;
    logic [CW-1:0] core;
  } seq_tag_t;
endpackage

// File: rtl/cache_slot_seq_ctr.sv
module cache_slot_seq_ctr #(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned SW = $clog2(NSLOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phase_i,
  output logic [SW-1:0] slot_o,
  output logic          wrap_o
);
  logic [SW-1:0] slot_q;

  // next slot is 0: either natural wrap or phase realign
  assign wrap_o = phase_i | (slot_q == SW'(NSLOT - 1));
  assign slot_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= '0;
    else if (wrap_o)  slot_q <= '0;
    else              slot_q <= slot_q + SW'(1);
  end
endmodule

// File: rtl/cache_slot_seq_map.sv
module cache_slot_seq_map
  import cache_slot_seq_pkg::*;
(
  input  seq_mode_e       mode_i,
  input  logic [CW-1:0]   slot_i,
  output logic [CW-1:0]   owner_o,
  output logic [NCORE-1:0] active_o,
  output logic [NWAY-1:0] way_o
);
  always_comb begin
    owner_o  = slot_i;
    active_o = '1;
    way_o    = '0;
    unique case (mode_i)
      MODE_ALL: begin
        owner_o  = slot_i;
        active_o = '1;
        way_o    = NWAY'(1) << slot_i;
      end
      MODE_PAIR: begin
        owner_o  = CW'(slot_i[0]);
        active_o = NCORE'(2'b11);
        way_o    = slot_i[0] ? NWAY'(4'b1010) : NWAY'(4'b0101);
      end
      default: begin
        owner_o  = '0;
        active_o = NCORE'(1);
        way_o    = '1;
      end
    endcase
  end
endmodule

// File: rtl/cache_slot_seq_mode.sv
module cache_slot_seq_mode
  import cache_slot_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  seq_mode_e mode_req_i,
  input  logic      wrap_i,
  input  logic      drained_i,
  output seq_mode_e mode_o,
  output logic      pend_o
);
  seq_mode_e mode_q;

  assign mode_o = mode_q;
  assign pend_o = (mode_req_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mode_q <= MODE_ALL;
    else if (pend_o && wrap_i && drained_i) mode_q <= mode_req_i;
  end
endmodule

// File: rtl/cache_slot_seq_trk.sv
module cache_slot_seq_trk
  import cache_slot_seq_pkg::*;
#(
  parameter int unsigned RESP_LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [CW-1:0] core_i,
  output seq_tag_t      tail_o,
  output logic          drained_o
);
  seq_tag_t stg_q [RESP_LAT];
  logic [RESP_LAT-1:0] vld;

  for (genvar g = 0; g < RESP_LAT; g++) begin : g_stg
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= '{vld: issue_i, core: core_i};
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
    assign vld[g] = stg_q[g].vld;
  end

  assign tail_o    = stg_q[RESP_LAT-1];
  assign drained_o = ~|vld;
endmodule

// File: rtl/cache_slot_seq.sv
module cache_slot_seq
  import cache_slot_seq_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 32,
  parameter int unsigned RESP_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_i,
  input  logic [1:0]       mode_i,
  input  logic [3:0]       core_req_i,
  input  logic [3:0]       core_we_i,
  input  logic [4*AW-1:0]  core_addr_i,
  input  logic [4*DW-1:0]  core_wdata_i,
  output logic [3:0]       core_gnt_o,
  output logic [3:0]       core_rvalid_o,
  output logic [DW-1:0]    core_rdata_o,
  output logic             cache_req_o,
  output logic             cache_we_o,
  output logic [AW-1:0]    cache_addr_o,
  output logic [DW-1:0]    cache_wdata_o,
  output logic [3:0]       cache_way_en_o,
  output logic [1:0]       cache_core_o,
  input  logic             cache_rvalid_i,
  input  logic [DW-1:0]    cache_rdata_i,
  output logic [1:0]       slot_o,
  output logic [1:0]       mode_o
);
  logic [CW-1:0]    slot, owner;
  logic             wrap, pend, drained, issue;
  logic [NCORE-1:0] active;
  logic [NWAY-1:0]  way;
  seq_mode_e        mode_cur;
  seq_tag_t         tail;
  logic [AW-1:0]    addr_arr  [NCORE];
  logic [DW-1:0]    wdata_arr [NCORE];

  for (genvar g = 0; g < NCORE; g++) begin : g_unpack
    assign addr_arr[g]  = core_addr_i[g*AW +: AW];
    assign wdata_arr[g] = core_wdata_i[g*DW +: DW];
  end

  cache_slot_seq_ctr #(.NSLOT(NCORE)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase_i),
    .slot_o (slot),
    .wrap_o (wrap)
  );

  cache_slot_seq_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_req_i(seq_mode_e'(mode_i)),
    .wrap_i    (wrap),
    .drained_i (drained),
    .mode_o    (mode_cur),
    .pend_o    (pend)
  );

  cache_slot_seq_map u_map (
    .mode_i  (mode_cur),
    .slot_i  (slot),
    .owner_o (owner),
    .active_o(active),
    .way_o   (way)
  );

  // pending mode change freezes issue so the tracker can drain
  assign issue = core_req_i[owner] & active[owner] & ~pend;

  cache_slot_seq_trk #(.RESP_LAT(RESP_LAT)) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_i  (issue),
    .core_i   (owner),
    .tail_o   (tail),
    .drained_o(drained)
  );

  assign cache_req_o    = issue;
  assign cache_we_o     = issue & core_we_i[owner];
  assign cache_addr_o   = addr_arr[owner];
  assign cache_wdata_o  = wdata_arr[owner];
  assign cache_core_o   = owner;
  assign cache_way_en_o = issue ? way : '0;
  assign core_gnt_o     = issue ? (NCORE'(1) << owner) : '0;

  assign core_rvalid_o  = (cache_rvalid_i & tail.vld) ? (NCORE'(1) << tail.core) : '0;
  assign core_rdata_o   = cache_rdata_i;

  assign slot_o = slot;
  assign mode_o = mode_cur;
endmodule

// File: rtl/cache_slot_seq_chk.sv
module cache_slot_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       phase_i,
  input logic [1:0] mode_i,
  input logic [3:0] core_req_i,
  input logic [3:0] core_gnt_o,
  input logic [3:0] core_rvalid_o,
  input logic       cache_req_o,
  input logic [3:0] cache_way_en_o,
  input logic [1:0] cache_core_o,
  input logic [1:0] slot_o,
  input logic [1:0] mode_o
);
  a_r1_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i |=> (slot_o == 2'($past(slot_o) + 2'd1)));

  a_r2_phase_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |=> (slot_o == 2'd0));

  a_r3_gnt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(core_gnt_o));

  a_r3_all_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_req_o && mode_o == 2'd0) |-> (cache_way_en_o == (4'b0001 << slot_o)));

  a_r4_pair_cores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> (core_gnt_o[3:2] == 2'b00));

  a_r5_solo_ways: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_req_o && mode_o[1]) |-> (cache_way_en_o == 4'hF && core_gnt_o == 4'b0001));

  a_r7_req_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_req_o |-> core_req_i[cache_core_o]);

  a_r8_rvalid_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(core_rvalid_o));

  a_r9_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_o) |-> !cache_req_o);

  a_r9_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> (slot_o == 2'd0));
endmodule

bind cache_slot_seq cache_slot_seq_chk u_chk (.*);

// File: tb/cache_slot_seq_tb_top.sv
module cache_slot_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LAT = 3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            phase_i = 1'b0;
  logic [1:0]      mode_i = 2'd0;
  logic [3:0]      core_req_i = '0;
  logic [3:0]      core_we_i = '0;
  logic [4*AW-1:0] core_addr_i = '0;
  logic [4*DW-1:0] core_wdata_i = '0;
  logic [3:0]      core_gnt_o, core_rvalid_o, cache_way_en_o;
  logic [DW-1:0]   core_rdata_o, cache_wdata_o;
  logic            cache_req_o, cache_we_o;
  logic [AW-1:0]   cache_addr_o;
  logic [1:0]      cache_core_o, slot_o, mode_o;
  logic            cache_rvalid_i = 1'b0;
  logic [DW-1:0]   cache_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  int bslot = 0;
  logic phase_en = 1'b1;

  always #4ns clk_i = ~clk_i;

  cache_slot_seq #(.AW(AW), .DW(DW), .RESP_LAT(LAT)) dut_i (.*);

  // {mode[15:14], slot[13:12], req[11:8], gnt[7:4], way[3:0]}
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'hF, 4'h1, 4'h1},  // R3
    {2'd0, 2'd1, 4'h2, 4'h2, 4'h2},  // R3
    {2'd0, 2'd2, 4'h1, 4'h0, 4'h0},  // R6 non-owner
    {2'd0, 2'd3, 4'h8, 4'h8, 4'h8},  // R3
    {2'd1, 2'd0, 4'h1, 4'h1, 4'h5},  // R4
    {2'd1, 2'd1, 4'hF, 4'h2, 4'hA},  // R4
    {2'd1, 2'd2, 4'hC, 4'h0, 4'h0},  // R6 disabled
    {2'd1, 2'd3, 4'h2, 4'h2, 4'hA},  // R4
    {2'd2, 2'd0, 4'h1, 4'h1, 4'hF},  // R5
    {2'd2, 2'd1, 4'hE, 4'h0, 4'h0},  // R6
    {2'd2, 2'd2, 4'hF, 4'h1, 4'hF},  // R5
    {2'd3, 2'd3, 4'h1, 4'h1, 4'hF},  // R5
    {2'd3, 2'd0, 4'h2, 4'h0, 4'h0},  // R6
    {2'd3, 2'd1, 4'h1, 4'h1, 4'hF},  // R5
    {2'd0, 2'd2, 4'h4, 4'h4, 4'h4},  // R3
    {2'd0, 2'd0, 4'h0, 4'h0, 4'h0}   // R6 idle
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2ns;
    if (phase_i) bslot = 0;
    else bslot = (bslot + 1) % 4;
    phase_i = phase_en && (bslot == 3);
  endtask

  task automatic set_mode(input logic [1:0] m);
    core_req_i = 4'hF;
    mode_i = m;
    for (int i = 0; i < 20 && mode_o != m; i++) begin
      #1ns;
      chk("R9 stall", {31'd0, cache_req_o}, 32'd0);
      tick();
    end
    #1ns;
    chk("R9 mode", {30'd0, mode_o}, {30'd0, m});
    chk("R9 boundary", {30'd0, slot_o}, 32'd0);
    core_req_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      core_addr_i[k*AW +: AW]  = AW'(16'h1000 + k * 16'h0111);
      core_wdata_i[k*DW +: DW] = DW'(32'hA0000000 + k * 32'h01010101);
    end
    // R10 reset state
    #13ns;
    chk("R10 slot", {30'd0, slot_o}, 32'd0);
    chk("R10 mode", {30'd0, mode_o}, 32'd0);
    chk("R10 req", {31'd0, cache_req_o}, 32'd0);
    chk("R10 rvalid", {28'd0, core_rvalid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bslot = 3;  // first edge brings slot 1, bench tracks from slot 0 wrap
    bslot = 0;
    phase_i = 1'b0;

    // R1 counting
    for (int i = 1; i < 6; i++) begin
      tick();
      #1ns;
      chk("R1 slot", {30'd0, slot_o}, 32'(i % 4));
    end

    // vector table
    for (int v = 0; v < NV; v++) begin
      if (mode_o != VEC[v][15:14]) set_mode(VEC[v][15:14]);
      for (int i = 0; i < 8 && bslot != int'(VEC[v][13:12]); i++) tick();
      core_req_i = VEC[v][11:8];
      #1ns;
      chk("R1 slot", {30'd0, slot_o}, {30'd0, VEC[v][13:12]});
      chk("R3-6 gnt", {28'd0, core_gnt_o}, {28'd0, VEC[v][7:4]});
      chk("R3-6 way", {28'd0, cache_way_en_o}, {28'd0, VEC[v][3:0]});
      chk("R6 req", {31'd0, cache_req_o}, {31'd0, |VEC[v][7:4]});
      tick();
      core_req_i = '0;
    end

    // R7 fields of serving core
    for (int i = 0; i < 8 && bslot != 1; i++) tick();
    core_req_i = 4'h2;
    core_we_i = 4'h2;
    #1ns;
    chk("R7 addr", {16'd0, cache_addr_o}, 32'h1111);
    chk("R7 wdata", cache_wdata_o, 32'hA1010101);
    chk("R7 we", {31'd0, cache_we_o}, 32'd1);
    chk("R7 core", {30'd0, cache_core_o}, 32'd1);
    tick();
    core_req_i = '0;
    core_we_i = '0;

    // R8 response routing after LAT edges
    for (int i = 0; i < 8 && bslot != 2; i++) tick();
    core_req_i = 4'h4;
    #1ns;
    chk("R8 issue", {28'd0, core_gnt_o}, 32'h4);
    tick();
    core_req_i = '0;
    for (int i = 1; i < LAT; i++) tick();
    cache_rvalid_i = 1'b1;
    cache_rdata_i = 32'hC0FFEE01;
    #1ns;
    chk("R8 rvalid", {28'd0, core_rvalid_o}, 32'h4);
    chk("R8 rdata", core_rdata_o, 32'hC0FFEE01);
    tick();
    cache_rvalid_i = 1'b0;
    #1ns;
    chk("R8 rvalid clear", {28'd0, core_rvalid_o}, 32'h0);

    // R2 phase realigns mid-cycle
    phase_en = 1'b0;
    for (int i = 0; i < 8 && bslot != 1; i++) tick();
    phase_i = 1'b1;
    phase_en = 1'b1;
    tick();
    #1ns;
    chk("R2 realign", {30'd0, slot_o}, 32'd0);
    tick();
    #1ns;
    chk("R1 after realign", {30'd0, slot_o}, 32'd1);

    // R10 reset mid-run
    set_mode(2'd1);
    #1ns;
    rst_ni = 1'b0;
    #1ns;
    chk("R10 async slot", {30'd0, slot_o}, 32'd0);
    chk("R10 async mode", {30'd0, mode_o}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule